// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Compare

This block is the integer execution unit of a small load/store processor. It takes the two register operands, the 16-bit immediate field and the opcode and function fields of the instruction. From these it forms one result word together with three flags. The datapath is a row of identical one-bit slices joined by a ripple carry chain. Each slice holds a full adder, an optional inverter on each operand input and a small result multiplexer. The block has no clock and no state: every output is a pure function of the present inputs.

Subtraction does not use a separate subtractor. One negate control inverts the B operand in every slice and also forces the carry into bit 0, so the adder computes a + ~b + 1. Set-less-than works through a per-slice "less" input. That input is zero on every bit except bit 0. Bit 0 receives the sign of the difference, corrected by the overflow flag for signed compares, or the inverted carry-out for unsigned compares. The zero flag serves equality branches. Overflow is reported only by the signed add and subtract forms.

The decoder is written like a state machine. The classifying step maps the instruction fields onto one named operation kind: K_ADD, K_ADDU, K_SUB, K_SUBU, K_AND, K_OR, K_XOR, K_NOR, K_SLT, K_SLTU, K_ADDI, K_ADDIU, K_SLTI, K_SLTIU, K_ANDI, K_ORI, K_XORI, K_LUI, or K_BAD for any other encoding. A second step turns that kind into the slice controls. There are no transitions between kinds, because every input combination is decoded on its own.

Top module: `int_alu_top`

## Requirements
- R1: Opcode 0x00 with funct 0x40 (ADD) or 0x41 (ADDU), and opcodes 0x10 (ADDI) and 0x11 (ADDIU), give result = A + B modulo 2^32, and carry_out = the carry out of bit 31.
- R2: Opcode 0x00 with funct 0x42 (SUB) or 0x43 (SUBU) gives result = A - B modulo 2^32, and carry_out = 1 exactly when A >= B as unsigned values.
- R3: overflow is 1 only for ADD, SUB and ADDI, and only when the signed result cannot be represented. Two operands of equal sign must produce a sum of the other sign, or two operands of differing sign must produce a difference whose sign differs from A. overflow is 0 for every other operation.
- R4: Opcode 0x00 with funct 0x44/0x45/0x46/0x47 gives AND/OR/XOR/NOR of A and B. Opcodes 0x14/0x15/0x16 give AND/OR/XOR of A with the immediate zero-extended to 32 bits.
- R5: Opcode 0x00 with funct 0x52 (SLT), and opcode 0x12 (SLTI), give 1 when A < B as two's complement numbers and 0 otherwise. This holds at the extreme values, where A - B overflows.
- R6: Opcode 0x00 with funct 0x53 (SLTU), and opcode 0x13 (SLTIU), give 1 when A < B as unsigned numbers. For SLTIU, B is the sign-extended immediate.
- R7: Opcode 0x17 (LUI) gives the immediate in bits 31..16 and zeros in bits 15..0, whatever rs_val holds.
- R8: zero is 1 exactly when all 32 result bits are 0, for every operation.
- R9: For ADDI, ADDIU, SLTI and SLTIU, the B operand is the immediate with bit 15 copied into bits 31..16.
- R10: carry_out is 0 for the logical operations (AND, OR, XOR, NOR, ANDI, ORI, XORI) and for LUI. For compares it is the carry of A - B.
- R11: Any other opcode, or opcode 0x00 with any other funct, gives result 0, carry_out 0, overflow 0 and zero 1.
- R12: For R-type operations the imm input has no effect. For I-type operations rt_val and funct have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 6 | Instruction opcode field; 0x00 selects R-type |
| funct | input | 7 | Function code for R-type operations |
| rs_val | input | 32 | Operand A |
| rt_val | input | 32 | Operand B for R-type operations |
| imm | input | 16 | Immediate field for I-type operations |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |
| carry_out | output | 1 | Carry out of bit 31 for arithmetic and compares |
| overflow | output | 1 | Signed overflow for ADD, SUB and ADDI |

## Verification
The hardest cases to reach are the signed compares whose subtraction overflows, for example the most negative value against a positive one. Here the raw sign bit of the difference gives the wrong answer, and only the overflow correction fed into bit 0 rescues it. Uniform random operands almost never land in this region. The stimulus therefore draws each operand half the time from a pool of extreme values (0, 1, all ones, the two signed limits and their neighbours) and mixes in directed vectors at those limits. A second hard case is the sign-extended immediate of SLTIU, which needs rs_val close to all ones. The bias pool covers it as well.

// File: rtl/alu_pkg.sv
package alu_pkg;

    // Instruction encodings; the decoder depends on these values.
    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_ADDI  = 6'h10;
    localparam logic [5:0] OPC_ADDIU = 6'h11;
    localparam logic [5:0] OPC_SLTI  = 6'h12;
    localparam logic [5:0] OPC_SLTIU = 6'h13;
    localparam logic [5:0] OPC_ANDI  = 6'h14;
    localparam logic [5:0] OPC_ORI   = 6'h15;
    localparam logic [5:0] OPC_XORI  = 6'h16;
    localparam logic [5:0] OPC_LUI   = 6'h17;

    localparam logic [6:0] FN_ADD  = 7'h40;
    localparam logic [6:0] FN_ADDU = 7'h41;
    localparam logic [6:0] FN_SUB  = 7'h42;
    localparam logic [6:0] FN_SUBU = 7'h43;
    localparam logic [6:0] FN_AND  = 7'h44;
    localparam logic [6:0] FN_OR   = 7'h45;
    localparam logic [6:0] FN_XOR  = 7'h46;
    localparam logic [6:0] FN_NOR  = 7'h47;
    localparam logic [6:0] FN_SLT  = 7'h52;
    localparam logic [6:0] FN_SLTU = 7'h53;

    // Per-slice result selection.
    typedef enum logic [2:0] {
        SEL_AND  = 3'd0,
        SEL_OR   = 3'd1,
        SEL_SUM  = 3'd2,
        SEL_LESS = 3'd3,
        SEL_XOR  = 3'd4
    } res_sel_e;

    // How the B operand is formed.
    typedef enum logic [1:0] {
        BSRC_REG   = 2'd0,
        BSRC_SIGN  = 2'd1,
        BSRC_ZERO  = 2'd2,
        BSRC_UPPER = 2'd3
    } bsrc_e;

    // Decoded operation kinds.
    typedef enum logic [4:0] {
        K_ADD, K_ADDU, K_SUB, K_SUBU,
        K_AND, K_OR, K_XOR, K_NOR,
        K_SLT, K_SLTU,
        K_ADDI, K_ADDIU, K_SLTI, K_SLTIU,
        K_ANDI, K_ORI, K_XORI, K_LUI,
        K_BAD
    } op_kind_e;

    typedef struct packed {
        logic     a_inv;       // invert A in every slice
        logic     negate;      // invert B and set carry-in of bit 0
        res_sel_e sel;         // slice result mux
        bsrc_e    bsrc;        // B operand source
        logic     a_zero;      // force A to zero
        logic     kill;        // undefined encoding: force both operands to zero
        logic     ovf_en;      // signed overflow reported
        logic     arith;       // carry_out reported
        logic     less_signed; // compare is signed
    } alu_ctrl_t;

    localparam alu_ctrl_t CTRL_IDLE = '{
        a_inv: 1'b0, negate: 1'b0, sel: SEL_AND, bsrc: BSRC_REG,
        a_zero: 1'b0, kill: 1'b0, ovf_en: 1'b0, arith: 1'b0,
        less_signed: 1'b0
    };

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
#(
    parameter int OP_W = 6,
    parameter int FN_W = 7
) (
    input  logic [OP_W-1:0] opcode,
    input  logic [FN_W-1:0] funct,
    output op_kind_e        kind,
    output alu_ctrl_t       ctrl
);

    // Classify the instruction fields into one named operation kind.
    always_comb begin
        kind = K_BAD;
        unique case (opcode)
            OPC_RTYPE: begin
                unique case (funct)
                    FN_ADD:  kind = K_ADD;
                    FN_ADDU: kind = K_ADDU;
                    FN_SUB:  kind = K_SUB;
                    FN_SUBU: kind = K_SUBU;
                    FN_AND:  kind = K_AND;
                    FN_OR:   kind = K_OR;
                    FN_XOR:  kind = K_XOR;
                    FN_NOR:  kind = K_NOR;
                    FN_SLT:  kind = K_SLT;
                    FN_SLTU: kind = K_SLTU;
                    default: kind = K_BAD;
                endcase
            end
            OPC_ADDI:  kind = K_ADDI;
            OPC_ADDIU: kind = K_ADDIU;
            OPC_SLTI:  kind = K_SLTI;
            OPC_SLTIU: kind = K_SLTIU;
            OPC_ANDI:  kind = K_ANDI;
            OPC_ORI:   kind = K_ORI;
            OPC_XORI:  kind = K_XORI;
            OPC_LUI:   kind = K_LUI;
            default:   kind = K_BAD;
        endcase
    end

    // Turn the operation kind into slice controls.
    always_comb begin
        ctrl = CTRL_IDLE;
        unique case (kind)
            K_ADD:   begin ctrl.sel = SEL_SUM; ctrl.arith = 1'b1; ctrl.ovf_en = 1'b1; end
            K_ADDU:  begin ctrl.sel = SEL_SUM; ctrl.arith = 1'b1; end
            K_SUB:   begin ctrl.sel = SEL_SUM; ctrl.negate = 1'b1; ctrl.arith = 1'b1; ctrl.ovf_en = 1'b1; end
            K_SUBU:  begin ctrl.sel = SEL_SUM; ctrl.negate = 1'b1; ctrl.arith = 1'b1; end
            K_AND:   ctrl.sel = SEL_AND;
            K_OR:    ctrl.sel = SEL_OR;
            K_XOR:   ctrl.sel = SEL_XOR;
            K_NOR:   begin ctrl.sel = SEL_AND; ctrl.a_inv = 1'b1; ctrl.negate = 1'b1; end
            K_SLT:   begin ctrl.sel = SEL_LESS; ctrl.negate = 1'b1; ctrl.arith = 1'b1; ctrl.less_signed = 1'b1; end
            K_SLTU:  begin ctrl.sel = SEL_LESS; ctrl.negate = 1'b1; ctrl.arith = 1'b1; end
            K_ADDI:  begin ctrl.sel = SEL_SUM; ctrl.bsrc = BSRC_SIGN; ctrl.arith = 1'b1; ctrl.ovf_en = 1'b1; end
            K_ADDIU: begin ctrl.sel = SEL_SUM; ctrl.bsrc = BSRC_SIGN; ctrl.arith = 1'b1; end
            K_SLTI:  begin ctrl.sel = SEL_LESS; ctrl.bsrc = BSRC_SIGN; ctrl.negate = 1'b1; ctrl.arith = 1'b1; ctrl.less_signed = 1'b1; end
            K_SLTIU: begin ctrl.sel = SEL_LESS; ctrl.bsrc = BSRC_SIGN; ctrl.negate = 1'b1; ctrl.arith = 1'b1; end
            K_ANDI:  begin ctrl.sel = SEL_AND; ctrl.bsrc = BSRC_ZERO; end
            K_ORI:   begin ctrl.sel = SEL_OR;  ctrl.bsrc = BSRC_ZERO; end
            K_XORI:  begin ctrl.sel = SEL_XOR; ctrl.bsrc = BSRC_ZERO; end
            K_LUI:   begin ctrl.sel = SEL_OR;  ctrl.bsrc = BSRC_UPPER; ctrl.a_zero = 1'b1; end
            K_BAD:   begin ctrl.sel = SEL_AND; ctrl.kill = 1'b1; end
            default: ctrl = CTRL_IDLE;
        endcase
    end

    // R3: only the signed add and subtract forms may enable overflow.
    always_comb begin
        assert_ovf_kinds_R3: assert (!ctrl.ovf_en || kind == K_ADD || kind == K_SUB || kind == K_ADDI)
            else $error("overflow enabled for kind %0d", kind);
    end

endmodule

// File: rtl/alu_operand.sv
module alu_operand
    import alu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16
) (
    input  logic [WIDTH-1:0] rs_val,
    input  logic [WIDTH-1:0] rt_val,
    input  logic [IMM_W-1:0] imm,
    input  alu_ctrl_t        ctrl,
    output logic [WIDTH-1:0] a_op,
    output logic [WIDTH-1:0] b_op
);

    localparam int EXT_W = WIDTH - IMM_W;

    logic [WIDTH-1:0] b_sel;

    always_comb begin
        unique case (ctrl.bsrc)
            BSRC_REG:   b_sel = rt_val;
            BSRC_SIGN:  b_sel = {{EXT_W{imm[IMM_W-1]}}, imm};
            BSRC_ZERO:  b_sel = {{EXT_W{1'b0}}, imm};
            BSRC_UPPER: b_sel = {imm, {EXT_W{1'b0}}} >> (EXT_W - IMM_W);
            default:    b_sel = rt_val;
        endcase
    end

    always_comb begin
        a_op = (ctrl.kill || ctrl.a_zero) ? '0 : rs_val;
        b_op = ctrl.kill ? '0 : b_sel;
    end

    // R9: a sign-extended immediate keeps its signed value.
    always_comb begin
        if (ctrl.bsrc == BSRC_SIGN && !ctrl.kill) begin
            assert_sign_ext_R9: assert ($signed(b_op) == $signed(imm))
                else $error("sign extension mismatch");
        end
    end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
(
    input  logic     a,
    input  logic     b,
    input  logic     a_inv,
    input  logic     b_inv,
    input  logic     cin,
    input  logic     less,
    input  res_sel_e sel,
    output logic     sum,
    output logic     cout,
    output logic     res
);

    logic a_eff;
    logic b_eff;

    always_comb begin
        a_eff = a ^ a_inv;
        b_eff = b ^ b_inv;
        sum   = a_eff ^ b_eff ^ cin;
        cout  = (a_eff & b_eff) | (a_eff & cin) | (b_eff & cin);
    end

    always_comb begin
        unique case (sel)
            SEL_AND:  res = a_eff & b_eff;
            SEL_OR:   res = a_eff | b_eff;
            SEL_SUM:  res = sum;
            SEL_LESS: res = less;
            SEL_XOR:  res = a_eff ^ b_eff;
            default:  res = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_op,
    input  logic [WIDTH-1:0] b_op,
    input  alu_ctrl_t        ctrl,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             overflow
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] less_in;
    logic             raw_ovf;
    logic             set_bit;

    assign carry[0] = ctrl.negate;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_slice
            if (i == 0) begin : g_lsb
                assign less_in[i] = set_bit;
            end else begin : g_upper
                assign less_in[i] = 1'b0;
            end
            alu_slice u_slice (
                .a     (a_op[i]),
                .b     (b_op[i]),
                .a_inv (ctrl.a_inv),
                .b_inv (ctrl.negate),
                .cin   (carry[i]),
                .less  (less_in[i]),
                .sel   (ctrl.sel),
                .sum   (sum[i]),
                .cout  (carry[i+1]),
                .res   (result[i])
            );
        end
    endgenerate

    always_comb begin
        raw_ovf   = carry[MSB] ^ carry[WIDTH];
        set_bit   = ctrl.less_signed ? (sum[MSB] ^ raw_ovf) : ~carry[WIDTH];
        carry_out = ctrl.arith & carry[WIDTH];
        overflow  = ctrl.ovf_en & raw_ovf;
    end

    // Guards comparing the slice chain with plain arithmetic.
    always_comb begin
        if (ctrl.sel == SEL_SUM && !ctrl.negate && !ctrl.a_inv) begin
            assert_add_value_R1: assert (result == a_op + b_op)
                else $error("add mismatch");
        end
        if (ctrl.sel == SEL_SUM && ctrl.negate) begin
            assert_sub_value_R2: assert (result == a_op - b_op)
                else $error("sub mismatch");
        end
        if (ctrl.sel == SEL_LESS && ctrl.less_signed) begin
            assert_slt_value_R5: assert (result == {{MSB{1'b0}}, ($signed(a_op) < $signed(b_op))})
                else $error("signed compare mismatch");
        end
        if (ctrl.sel == SEL_LESS && !ctrl.less_signed) begin
            assert_sltu_value_R6: assert (result == {{MSB{1'b0}}, (a_op < b_op)})
                else $error("unsigned compare mismatch");
        end
        if (ctrl.sel == SEL_XOR) begin
            assert_xor_value_R4: assert (result == (a_op ^ b_op))
                else $error("xor mismatch");
        end
        if (overflow && ctrl.sel == SEL_SUM) begin
            assert_ovf_sign_R3: assert (a_op[MSB] == (b_op[MSB] ^ ctrl.negate) && result[MSB] != a_op[MSB])
                else $error("overflow without sign change");
        end
    end

endmodule

// File: rtl/int_alu_top.sv
module int_alu_top
    import alu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16,
    parameter int OP_W  = 6,
    parameter int FN_W  = 7
) (
    input  logic [OP_W-1:0]  opcode,
    input  logic [FN_W-1:0]  funct,
    input  logic [WIDTH-1:0] rs_val,
    input  logic [WIDTH-1:0] rt_val,
    input  logic [IMM_W-1:0] imm,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             carry_out,
    output logic             overflow
);

    op_kind_e         kind;
    alu_ctrl_t        ctrl;
    logic [WIDTH-1:0] a_op;
    logic [WIDTH-1:0] b_op;

    alu_decode #(.OP_W(OP_W), .FN_W(FN_W)) u_decode (
        .opcode (opcode),
        .funct  (funct),
        .kind   (kind),
        .ctrl   (ctrl)
    );

    alu_operand #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_operand (
        .rs_val (rs_val),
        .rt_val (rt_val),
        .imm    (imm),
        .ctrl   (ctrl),
        .a_op   (a_op),
        .b_op   (b_op)
    );

    alu_core #(.WIDTH(WIDTH)) u_core (
        .a_op      (a_op),
        .b_op      (b_op),
        .ctrl      (ctrl),
        .result    (result),
        .carry_out (carry_out),
        .overflow  (overflow)
    );

    assign zero = ~|result;

    // R7 / R11: upper-immediate loads and undefined encodings at the ports.
    always_comb begin
        if (kind == K_LUI) begin
            assert_lui_place_R7: assert (result[IMM_W-1:0] == '0 && result[WIDTH-1:WIDTH-IMM_W] == imm)
                else $error("upper immediate misplaced");
        end
        if (kind == K_BAD) begin
            assert_bad_quiet_R11: assert (zero && !carry_out && !overflow)
                else $error("undefined encoding not quiet");
        end
    end

endmodule

// File: tb/test_int_alu_top.sv
module test_int_alu_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  opcode = '0;
    logic [6:0]  funct = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [15:0] imm = '0;
    logic [31:0] result;
    logic        zero;
    logic        carry_out;
    logic        overflow;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    int_alu_top i_int_alu_top (
        .opcode    (opcode),
        .funct     (funct),
        .rs_val    (rs_val),
        .rt_val    (rt_val),
        .imm       (imm),
        .result    (result),
        .zero      (zero),
        .carry_out (carry_out),
        .overflow  (overflow)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Reference model written from the requirements.
    task automatic model(input logic [5:0] op, input logic [6:0] fn,
                         input logic [31:0] a, input logic [31:0] rt, input logic [15:0] im,
                         output logic [31:0] r, output logic c, output logic v, output string tag);
        logic [31:0] se;
        logic [31:0] ze;
        logic [31:0] b;
        logic [32:0] s;
        logic [32:0] d;
        se = {{16{im[15]}}, im};
        ze = {16'h0, im};
        r = '0; c = 1'b0; v = 1'b0; tag = "R11";
        b = rt;
        if (op != 6'h00) b = (op >= 6'h14) ? ze : se;
        s = {1'b0, a} + {1'b0, b};
        d = {1'b0, a} + {1'b0, ~b} + 33'd1;
        if (op == 6'h00) begin
            case (fn)
                7'h40, 7'h41: begin r = s[31:0]; c = s[32]; tag = "R1";
                    if (fn == 7'h40) v = (a[31] == b[31]) && (r[31] != a[31]); end
                7'h42, 7'h43: begin r = d[31:0]; c = d[32]; tag = "R2";
                    if (fn == 7'h42) v = (a[31] != b[31]) && (r[31] != a[31]); end
                7'h44: begin r = a & b; tag = "R4"; end
                7'h45: begin r = a | b; tag = "R4"; end
                7'h46: begin r = a ^ b; tag = "R4"; end
                7'h47: begin r = ~(a | b); tag = "R4"; end
                7'h52: begin r = {31'd0, $signed(a) < $signed(b)}; c = d[32]; tag = "R5"; end
                7'h53: begin r = {31'd0, a < b}; c = d[32]; tag = "R6"; end
                default: ;
            endcase
        end else begin
            case (op)
                6'h10, 6'h11: begin r = s[31:0]; c = s[32]; tag = "R9";
                    if (op == 6'h10) v = (a[31] == b[31]) && (r[31] != a[31]); end
                6'h12: begin r = {31'd0, $signed(a) < $signed(b)}; c = d[32]; tag = "R5"; end
                6'h13: begin r = {31'd0, a < b}; c = d[32]; tag = "R6"; end
                6'h14: begin r = a & b; tag = "R4"; end
                6'h15: begin r = a | b; tag = "R4"; end
                6'h16: begin r = a ^ b; tag = "R4"; end
                6'h17: begin r = {im, 16'h0}; tag = "R7"; end
                default: ;
            endcase
        end
    endtask

    task automatic apply(input logic [5:0] op, input logic [6:0] fn,
                         input logic [31:0] a, input logic [31:0] rt, input logic [15:0] im,
                         input string note);
        logic [31:0] er;
        logic ec;
        logic ev;
        string tag;
        @(posedge clk);
        opcode = op; funct = fn; rs_val = a; rt_val = rt; imm = im;
        model(op, fn, a, rt, im, er, ec, ev, tag);
        @(negedge clk);
        checks = checks + 1;
        if (result !== er || zero !== (er == 32'd0) || carry_out !== ec || overflow !== ev) begin
            errors = errors + 1;
            $display("FAIL %s %s op=%h fn=%h a=%h b=%h imm=%h: actual r=%h z=%b c=%b v=%b expected r=%h z=%b c=%b v=%b (R8 R10)",
                     tag, note, op, fn, a, rt, im, result, zero, carry_out, overflow,
                     er, (er == 32'd0), ec, ev);
        end
    endtask

    function automatic logic [31:0] pick();
        logic [31:0] pool [10];
        pool = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000,
                 32'h8000_0001, 32'h7FFF_FFFE, 32'hFFFF_FFFE, 32'h0000_FFFF, 32'hFFFF_8000};
        if ($urandom_range(1, 0) == 0) return pool[$urandom_range(9, 0)];
        return $urandom;
    endfunction

    initial begin
        logic [5:0] ops [18];
        logic [6:0] fns [18];
        logic [31:0] r1;
        logic [31:0] r2;
        ops = '{6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 6'h00, 6'h00,
                6'h10, 6'h11, 6'h12, 6'h13, 6'h14, 6'h15, 6'h16, 6'h17};
        fns = '{7'h40, 7'h41, 7'h42, 7'h43, 7'h44, 7'h45, 7'h46, 7'h47, 7'h52, 7'h53,
                7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00};
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Reset-time inputs (all zero) decode as undefined: R11.
        apply(6'h00, 7'h00, 32'h0, 32'h0, 16'h0, "reset state R11");

        // Directed corner cases.
        apply(6'h00, 7'h40, 32'h7FFF_FFFF, 32'h1, 16'h0, "ADD pos overflow R3");
        apply(6'h00, 7'h41, 32'h7FFF_FFFF, 32'h1, 16'h0, "ADDU no overflow R3");
        apply(6'h00, 7'h40, 32'h8000_0000, 32'h8000_0000, 16'h0, "ADD neg overflow R3 R8");
        apply(6'h00, 7'h42, 32'h8000_0000, 32'h1, 16'h0, "SUB overflow R2 R3");
        apply(6'h00, 7'h43, 32'h8000_0000, 32'h1, 16'h0, "SUBU no overflow R2");
        apply(6'h00, 7'h42, 32'h1234_5678, 32'h1234_5678, 16'h0, "SUB equal zero R8");
        apply(6'h00, 7'h41, 32'hFFFF_FFFF, 32'h1, 16'h0, "ADDU carry R1");
        apply(6'h10, 7'h00, 32'h5, 32'h0, 16'hFFFF, "ADDI negative imm R9");
        apply(6'h10, 7'h00, 32'h7FFF_FFFF, 32'h0, 16'h0001, "ADDI overflow R3");
        apply(6'h11, 7'h00, 32'h7FFF_FFFF, 32'h0, 16'h0001, "ADDIU no overflow R3");
        apply(6'h00, 7'h52, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, "SLT extreme R5");
        apply(6'h00, 7'h52, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, "SLT extreme rev R5");
        apply(6'h00, 7'h53, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, "SLTU extreme R6");
        apply(6'h12, 7'h00, 32'hFFFF_FFFE, 32'h0, 16'hFFFF, "SLTI negative imm R5 R9");
        apply(6'h13, 7'h00, 32'h5, 32'h0, 16'hFFFF, "SLTIU sign-extended R6");
        apply(6'h14, 7'h00, 32'hFFFF_FFFF, 32'h0, 16'h8000, "ANDI zero-extend R4");
        apply(6'h15, 7'h00, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, "ORI no carry R10");
        apply(6'h00, 7'h47, 32'h0, 32'h0, 16'h0, "NOR zeros R4 R10");
        apply(6'h17, 7'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hABCD, "LUI ignores A R7");
        apply(6'h3F, 7'h40, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, "undefined op R11");
        apply(6'h00, 7'h7F, 32'hFFFF_FFFF, 32'h1, 16'h0, "undefined funct R11");

        // R12: imm ignored for R-type, rt_val and funct ignored for I-type.
        apply(6'h00, 7'h40, 32'h1111, 32'h2222, 16'h0, "ADD imm 0 R12");
        r1 = result;
        apply(6'h00, 7'h40, 32'h1111, 32'h2222, 16'hBEEF, "ADD imm set R12");
        r2 = result;
        checks = checks + 1;
        if (r1 !== r2) begin
            errors = errors + 1;
            $display("FAIL R12 imm changed R-type result: actual %h expected %h", r2, r1);
        end
        apply(6'h10, 7'h00, 32'h1111, 32'h0, 16'h0100, "ADDI rt 0 R12");
        r1 = result;
        apply(6'h10, 7'h7F, 32'h1111, 32'hDEAD_BEEF, 16'h0100, "ADDI rt set R12");
        r2 = result;
        checks = checks + 1;
        if (r1 !== r2) begin
            errors = errors + 1;
            $display("FAIL R12 rt/funct changed I-type result: actual %h expected %h", r2, r1);
        end

        // Constrained random over the valid encodings, biased to extremes.
        for (int n = 0; n < 3000; n++) begin
            int k;
            logic [6:0] fn;
            k = $urandom_range(17, 0);
            fn = (ops[k] == 6'h00) ? fns[k] : 7'($urandom);
            apply(ops[k], fn, pick(), pick(), 16'($urandom), "random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule